// File: doc/BRIEF.md
# Burst Memory Slave with Wait States

A small word-organised memory placed behind a memory-mapped slave port that uses byte addresses, a stall (wait request) output and a separate read-data-valid output. A master holds its command on the port until it sees the stall output low at a rising edge. That edge accepts the command. Single-word accesses are taken at once. A single write merges only the bytes chosen by the byte mask into the stored word. Read data returns a fixed, configurable number of cycles after acceptance.

Multi-word transfers use a burst count. A burst read stalls for a fixed two cycles. It then returns the words one per cycle from consecutive addresses. A burst write stalls in a pseudo-random pattern before each beat. The pattern comes from a 16-bit LFSR with a fixed seed, so a test replays the same wait states after every reset. A word that has never been written reads as a configurable poison pattern. A malformed burst is dropped and leaves a sticky error flag set.

Top module: `mem_burst_slave`

## Requirements
- R1: While reset is held and after its release with no command present, `s_stall` equals `WR_JITTER_EN`, `s_rvalid` is 0 and `s_err` is 0.
- R2: A command with `s_burst` = 1 is a single access. It is accepted in the cycle it appears, with `s_stall` low, and it addresses word `s_addr[ADDR_W-1:2]` (for 32-bit data the two low bits are ignored). On a write, `s_be` bit i selects byte i, which is bits 8i+7..8i. Selected bytes take the new data and the other bytes keep their contents.
- R3: A word not written since reset reads as `POISON` with `s_rvalid` high. A masked write to such a word merges into `POISON`.
- R4: A read accepted at edge k drives `s_rvalid` high with its data in the cycle after edge k+`RD_LAT`-1, for exactly one cycle per word. `s_rvalid` is low in every other cycle.
- R5: A burst read (`s_burst` > 1) keeps `s_stall` high in the cycle the command first appears and in the next cycle. `s_stall` drops in the third cycle, which accepts the command.
- R6: A burst read returns `s_burst` words from consecutive word indices, starting at the base word and wrapping modulo `WORDS`. The beats come on consecutive cycles, and the first beat is timed as in R4. `s_stall` stays high until the last beat has been issued.
- R7: A burst write stores its beats as full words at consecutive word indices from the base, wrapping modulo `WORDS`. A cycle with `s_stall` low and `s_wr` low stores nothing and does not advance the beat.
- R8: A burst write stalls for at least one cycle before its first beat. No stall run before any beat is longer than `MAX_WAIT`+1 cycles. A wait is drawn with probability one in four from the LFSR.
- R9: A command with `s_burst` = 0 is malformed. So is a burst whose address has nonzero low bits or whose `s_be` is not all ones. A malformed command is accepted with no stall, writes nothing and returns no data. It sets `s_err` from the next cycle, and `s_err` then stays high until reset.
- R10: The LFSR restarts from `SEED` at reset. The same stimulus after each reset produces the same stall sequence.
- R11: When a burst write completes, the block is idle again and `s_stall` rests at `WR_JITTER_EN` while no command is present.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| s_addr | input | ADDR_W | Byte address |
| s_rd | input | 1 | Read command |
| s_wr | input | 1 | Write command / write beat |
| s_wdata | input | DATA_W | Write data |
| s_be | input | DATA_W/8 | Byte mask, bit i for byte i |
| s_burst | input | BURST_W | Number of words in the transfer |
| s_stall | output | 1 | High: command or beat not accepted this cycle |
| s_rdata | output | DATA_W | Read data |
| s_rvalid | output | 1 | Read data valid |
| s_err | output | 1 | Sticky malformed-command flag |

## Verification
A wrong beat counter or word index is visible within a single burst. The bench sees too many or too few `s_rvalid` cycles, or words from the wrong location, in the cycle they are due. A corrupted byte merge or lost written-flag appears on the next readback of that word. A wait counter or LFSR in a bad state shows on the port as an overlong stall run before a write beat, or as a stall sequence that differs between two identical runs after reset. An error latch that drops, or fires on good traffic, is visible on `s_err` one cycle later.

// File: rtl/mem_slv_pkg.sv
package mem_slv_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD_HOLD,
    ST_RD_GO,
    ST_RD_SEND,
    ST_WR
  } slv_st_e;
endpackage

// File: rtl/mem_lfsr16.sv
module mem_lfsr16 #(
  parameter logic [15:0] SEED = 16'hACE1
) (
  input  logic        clk,
  input  logic        rst_n,
  output logic [15:0] q
);
  logic [15:0] q_nx;

  // taps 16,14,13,11
  always_comb q_nx = {q[14:0], q[15] ^ q[13] ^ q[12] ^ q[10]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= SEED;
    else        q <= q_nx;
  end

  // R10: seeded register never falls into the all-zero lock state
  a_r10_lfsr_live: assert property (@(posedge clk) disable iff (!rst_n) q != 16'h0);
endmodule

// File: rtl/mem_rd_pipe.sv
module mem_rd_pipe #(
  parameter int DATA_W = 32,
  parameter int LAT    = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_vld,
  input  logic [DATA_W-1:0] in_data,
  output logic              out_vld,
  output logic [DATA_W-1:0] out_data
);
  logic [LAT-1:0]    vq;
  logic [LAT:0]      v_chain;
  logic [DATA_W-1:0] dq      [LAT];
  logic [DATA_W-1:0] d_chain [LAT+1];

  always_comb begin
    v_chain    = {vq, in_vld};
    d_chain[0] = in_data;
    for (int i = 1; i <= LAT; i++) d_chain[i] = dq[i-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vq <= '0;
    else        vq <= v_chain[LAT-1:0];
  end

  // data stages load only when their valid moves in (clock enable)
  always_ff @(posedge clk) begin
    for (int i = 0; i < LAT; i++) begin
      if (v_chain[i]) dq[i] <= d_chain[i];
    end
  end

  assign out_vld  = vq[LAT-1];
  assign out_data = dq[LAT-1];
endmodule

// File: rtl/mem_store.sv
module mem_store #(
  parameter int                DATA_W = 32,
  parameter int                WORDS  = 16,
  parameter logic [DATA_W-1:0] POISON = '1,
  localparam int               BYTES  = DATA_W / 8,
  localparam int               IDX_W  = $clog2(WORDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [BYTES-1:0]  wr_be,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [DATA_W-1:0] rd_data
);
  logic [DATA_W-1:0] mem [WORDS];
  logic [WORDS-1:0]  wrt;
  logic [DATA_W-1:0] cur;
  logic [DATA_W-1:0] merged;

  always_comb begin
    cur    = wrt[wr_idx] ? mem[wr_idx] : POISON;
    merged = cur;
    for (int b = 0; b < BYTES; b++) begin
      if (wr_be[b]) merged[8*b +: 8] = wr_data[8*b +: 8];
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_idx] <= merged;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     wrt         <= '0;
    else if (wr_en) wrt[wr_idx] <= 1'b1;
  end

  assign rd_data = wrt[rd_idx] ? mem[rd_idx] : POISON;

  // R3: a stored word is no longer reported as poison afterwards
  a_r3_marked: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> wrt[$past(wr_idx)]);
endmodule

// File: rtl/mem_burst_slave.sv
module mem_burst_slave import mem_slv_pkg::*; #(
  parameter int                DATA_W       = 32,
  parameter int                WORDS        = 16,
  parameter int                BURST_W      = 4,
  parameter int                RD_LAT       = 1,
  parameter int                MAX_WAIT     = 4,
  parameter bit                WR_JITTER_EN = 1'b1,
  parameter logic [15:0]       SEED         = 16'hACE1,
  parameter logic [DATA_W-1:0] POISON       = {(DATA_W/8){8'hA5}},
  parameter int                ADDR_W       = $clog2(WORDS) + $clog2(DATA_W/8)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [ADDR_W-1:0]     s_addr,
  input  logic                  s_rd,
  input  logic                  s_wr,
  input  logic [DATA_W-1:0]     s_wdata,
  input  logic [DATA_W/8-1:0]   s_be,
  input  logic [BURST_W-1:0]    s_burst,
  output logic                  s_stall,
  output logic [DATA_W-1:0]     s_rdata,
  output logic                  s_rvalid,
  output logic                  s_err
);
  localparam int BYTES  = DATA_W / 8;
  localparam int LB     = $clog2(BYTES);
  localparam int IDX_W  = $clog2(WORDS);
  localparam int WAIT_W = $clog2(MAX_WAIT + 1);

  // reset: asserted asynchronously, released after two clock edges
  logic [1:0] rs_q;
  logic       rs_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rs_n = rs_q[1];

  slv_st_e            st, st_nx;
  logic [IDX_W-1:0]   idx_q, idx_nx;
  logic [BURST_W-1:0] rem_q, rem_nx;
  logic [WAIT_W-1:0]  wcnt_q, wcnt_nx;
  logic               err_q, err_nx;

  logic [15:0]        lfsr_q;
  logic [7:0]         dmod;
  logic [WAIT_W-1:0]  draw;

  logic               req, multi, bad, single_ok, brst_ok;
  logic [IDX_W-1:0]   in_idx;

  logic               push;
  logic [IDX_W-1:0]   push_idx;
  logic [DATA_W-1:0]  push_data;
  logic               wr_en;
  logic [IDX_W-1:0]   wr_idx;
  logic [BYTES-1:0]   wr_be;

  mem_lfsr16 #(.SEED(SEED)) u_lfsr (.clk(clk), .rst_n(rs_n), .q(lfsr_q));

  // one-in-four wait, length 0..MAX_WAIT
  assign dmod = lfsr_q[15:8] % 8'(MAX_WAIT + 1);
  assign draw = (WR_JITTER_EN && lfsr_q[1:0] == 2'b00) ? WAIT_W'(dmod) : '0;

  // command decode, used in idle only
  assign req       = s_rd | s_wr;
  assign multi     = s_burst > BURST_W'(1);
  assign bad       = (s_burst == '0) | (multi & ((|s_addr[LB-1:0]) | (s_be != '1)));
  assign single_ok = req & (s_burst == BURST_W'(1));
  assign brst_ok   = req & multi & ~bad;
  assign in_idx    = s_addr[ADDR_W-1:LB];

  always_comb begin
    st_nx    = st;
    idx_nx   = idx_q;
    rem_nx   = rem_q;
    wcnt_nx  = wcnt_q;
    err_nx   = err_q;
    s_stall  = 1'b0;
    push     = 1'b0;
    push_idx = idx_q;
    wr_en    = 1'b0;
    wr_idx   = idx_q;
    wr_be    = '1;
    unique case (st)
      ST_IDLE: begin
        s_stall = brst_ok | (WR_JITTER_EN & ~req);
        if (req & bad) begin
          err_nx = 1'b1;
        end else if (single_ok) begin
          if (s_rd) begin
            push     = 1'b1;
            push_idx = in_idx;
          end else begin
            wr_en  = 1'b1;
            wr_idx = in_idx;
            wr_be  = s_be;
          end
        end else if (brst_ok) begin
          idx_nx = in_idx;
          rem_nx = s_burst;
          if (s_rd) begin
            st_nx = ST_RD_HOLD;
          end else begin
            st_nx   = ST_WR;
            wcnt_nx = draw;
          end
        end
      end
      ST_RD_HOLD: begin
        s_stall = 1'b1;
        st_nx   = ST_RD_GO;
      end
      ST_RD_GO, ST_RD_SEND: begin
        s_stall = (st == ST_RD_SEND);
        push    = 1'b1;
        idx_nx  = idx_q + IDX_W'(1);
        rem_nx  = rem_q - BURST_W'(1);
        if (st == ST_RD_GO)             st_nx = ST_RD_SEND;
        else if (rem_q == BURST_W'(1))  st_nx = ST_IDLE;
      end
      ST_WR: begin
        s_stall = (wcnt_q != '0);
        if (wcnt_q != '0) begin
          wcnt_nx = wcnt_q - WAIT_W'(1);
        end else if (s_wr) begin
          wr_en  = 1'b1;
          idx_nx = idx_q + IDX_W'(1);
          rem_nx = rem_q - BURST_W'(1);
          if (rem_q == BURST_W'(1)) st_nx   = ST_IDLE;
          else                      wcnt_nx = draw;
        end
      end
      default: st_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rs_n) begin
    if (!rs_n) begin
      st     <= ST_IDLE;
      idx_q  <= '0;
      rem_q  <= '0;
      wcnt_q <= '0;
      err_q  <= 1'b0;
    end else begin
      st     <= st_nx;
      idx_q  <= idx_nx;
      rem_q  <= rem_nx;
      wcnt_q <= wcnt_nx;
      err_q  <= err_nx;
    end
  end

  mem_store #(.DATA_W(DATA_W), .WORDS(WORDS), .POISON(POISON)) u_store (
    .clk(clk), .rst_n(rs_n),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_be(wr_be), .wr_data(s_wdata),
    .rd_idx(push_idx), .rd_data(push_data)
  );

  mem_rd_pipe #(.DATA_W(DATA_W), .LAT(RD_LAT)) u_pipe (
    .clk(clk), .rst_n(rs_n),
    .in_vld(push), .in_data(push_data),
    .out_vld(s_rvalid), .out_data(s_rdata)
  );

  assign s_err = err_q;

  // R5: second hold cycle is always followed by release
  a_r5_hold_release: assert property (@(posedge clk) disable iff (!rs_n)
    (st == ST_RD_HOLD) |=> !s_stall);
  // R6: a sending burst always has beats left
  a_r6_beats_left: assert property (@(posedge clk) disable iff (!rs_n)
    (st == ST_RD_SEND) |-> (rem_q != '0));
  // R8: wait counter stays within its limit
  a_r8_wait_bound: assert property (@(posedge clk) disable iff (!rs_n)
    wcnt_q <= WAIT_W'(MAX_WAIT));
  // R9: error flag never clears outside reset
  a_r9_err_sticky: assert property (@(posedge clk) disable iff (!rs_n)
    s_err |=> s_err);
endmodule

// File: tb/test_mem_burst_slave.sv
module test_mem_burst_slave;
  localparam int          DW    = 32;
  localparam int          WORDS = 16;
  localparam int          AW    = 6;
  localparam int          BW    = 4;
  localparam int          LAT   = 2;
  localparam int          MAXW  = 4;
  localparam logic [31:0] POISON = 32'hA5A5_A5A5;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] s_addr = '0;
  logic          s_rd = 1'b0, s_wr = 1'b0;
  logic [DW-1:0] s_wdata = '0;
  logic [3:0]    s_be = '0;
  logic [BW-1:0] s_burst = 4'd1;
  logic          s_stall, s_rvalid, s_err;
  logic [DW-1:0] s_rdata;

  always #5 clk = ~clk;

  mem_burst_slave #(.DATA_W(DW), .WORDS(WORDS), .BURST_W(BW), .RD_LAT(LAT),
                    .MAX_WAIT(MAXW), .WR_JITTER_EN(1'b1), .POISON(POISON)) i_mem_burst_slave (
    .clk(clk), .rst_n(rst_n), .s_addr(s_addr), .s_rd(s_rd), .s_wr(s_wr),
    .s_wdata(s_wdata), .s_be(s_be), .s_burst(s_burst), .s_stall(s_stall),
    .s_rdata(s_rdata), .s_rvalid(s_rvalid), .s_err(s_err));

  int checks = 0, errors = 0, ecnt = 0;
  bit chk_en = 1'b0, done = 1'b0;
  logic [31:0] mm [WORDS];
  bit          mw [WORDS];
  int          q_due[$];
  logic [31:0] q_dat[$];

  always @(posedge clk) ecnt <= ecnt + 1;

  task automatic chk(input bit ok, input string r, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h t=%0t", r, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] view(input int i);
    return mw[i] ? mm[i] : POISON;
  endfunction

  // per-clock comparison of the read return port (R4, R6)
  always @(negedge clk) begin
    if (chk_en) begin
      if (q_due.size() > 0 && q_due[0] < ecnt) begin
        chk(1'b0, "R4 missed beat", 64'(ecnt), 64'(q_due[0]));
        void'(q_due.pop_front()); void'(q_dat.pop_front());
      end else if (q_due.size() > 0 && q_due[0] == ecnt) begin
        chk(s_rvalid && s_rdata == q_dat[0], "R4 R6 beat", {31'd0, s_rvalid, s_rdata}, {32'd1, q_dat[0]});
        void'(q_due.pop_front()); void'(q_dat.pop_front());
      end else begin
        chk(!s_rvalid, "R4 idle rvalid", 64'(s_rvalid), 64'd0);
      end
    end
  end

  task automatic idle();
    s_rd = 1'b0; s_wr = 1'b0; s_be = '0; s_burst = 4'd1;
  endtask

  // wait for acceptance; model read returns at the accepting edge
  task automatic hs(output int acc, output int stl);
    bit bad;
    int ix;
    stl = 0; acc = -1;
    while (acc < 0) begin
      #1;
      if (!s_stall) begin
        acc = ecnt + 1;
        bad = (s_burst == 0) || (s_burst > 1 && (s_addr[1:0] != 0 || s_be != 4'hF));
        if (s_rd && !bad) begin
          for (int i = 0; i < int'(s_burst); i++) begin
            ix = (int'(s_addr >> 2) + i) % WORDS;
            q_due.push_back(acc + LAT - 1 + i);
            q_dat.push_back(view(ix));
          end
        end
      end else begin
        stl++;
      end
      @(negedge clk);
      if (acc < 0 && stl > 40) begin
        chk(1'b0, "R8 stuck stall", 64'(stl), 64'd0);
        acc = ecnt;
      end
    end
  endtask

  task automatic swrite(input int a, input logic [3:0] be, input logic [31:0] d);
    int acc, stl;
    logic [31:0] cur;
    s_rd = 0; s_wr = 1; s_addr = AW'(a); s_be = be; s_wdata = d; s_burst = 4'd1;
    hs(acc, stl);
    chk(stl == 0, "R2 single no stall", 64'(stl), 64'd0);
    cur = view(a >> 2);
    for (int b = 0; b < 4; b++) if (be[b]) cur[8*b +: 8] = d[8*b +: 8];
    mm[a >> 2] = cur; mw[a >> 2] = 1'b1;
    idle();
  endtask

  task automatic sread(input int a);
    int acc, stl;
    s_rd = 1; s_wr = 0; s_addr = AW'(a); s_be = 4'hF; s_burst = 4'd1;
    hs(acc, stl);
    idle();
  endtask

  task automatic bread(input int a, input int n, input int exp_stl);
    int acc, stl;
    s_rd = 1; s_wr = 0; s_addr = AW'(a); s_be = 4'hF; s_burst = BW'(n);
    hs(acc, stl);
    chk(stl == exp_stl, "R5 burst read stall", 64'(stl), 64'(exp_stl));
    idle();
  endtask

  task automatic bwrite(input int a, input int n, input logic [31:0] base, input bit gap, output int sig);
    int acc, stl;
    sig = 0;
    for (int i = 0; i < n; i++) begin
      s_rd = 0; s_wr = 1; s_addr = AW'(a); s_be = 4'hF; s_burst = BW'(n);
      s_wdata = base + 32'(i * 32'h0101_0101);
      hs(acc, stl);
      chk(stl <= MAXW + 1, "R8 stall run bound", 64'(stl), 64'(MAXW + 1));
      if (i == 0) chk(stl >= 1, "R8 first beat stall", 64'(stl), 64'd1);
      mm[((a >> 2) + i) % WORDS] = s_wdata; mw[((a >> 2) + i) % WORDS] = 1'b1;
      sig = sig * 31 + stl + 1;
      if (gap && i < n - 1) begin
        s_wr = 0;
        @(negedge clk);
      end
    end
    idle();
    #1 chk(s_stall == 1'b1, "R11 rest high after burst", 64'(s_stall), 64'd1);
  endtask

  task automatic drain();
    int g = 0;
    while (q_due.size() > 0 && g < 50) begin @(negedge clk); g++; end
    @(negedge clk);
  endtask

  task automatic do_reset();
    chk_en = 0; rst_n = 0; idle();
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    q_due.delete(); q_dat.delete();
    for (int i = 0; i < WORDS; i++) mw[i] = 1'b0;
    chk_en = 1;
  endtask

  initial begin
    int acc, stl, sig1, sig2;
    @(negedge clk);
    rst_n = 0; idle();
    #1 chk(s_stall == 1'b1 && s_rvalid == 1'b0, "R1 in reset", {s_stall, s_rvalid}, 2'b10);
    do_reset();
    #1 chk(s_stall == 1'b1, "R1 idle stall", 64'(s_stall), 64'd1);
    chk(s_rvalid == 1'b0 && s_err == 1'b0, "R1 outputs", {s_rvalid, s_err}, 2'b00);

    // R3 poison, R2 merge, R4 latency
    sread(4);
    swrite(4, 4'hF, 32'h1122_3344);
    sread(4);
    swrite(5, 4'b0101, 32'hAABB_CCDD);   // low bits ignored, word 1
    sread(4);
    swrite(16, 4'b0010, 32'h0000_7700);  // never-written word 4
    sread(16);
    sread(0); sread(4); sread(16);       // back-to-back
    drain();

    // R5/R6 burst read over written and poison words
    bread(0, 5, 2);
    drain();

    // R7 burst write with skipped cycles, read back
    bwrite(32, 5, 32'h1000_0001, 1'b1, sig1);
    bread(32, 5, 2);
    drain();
    // wrap around the top of the array
    bwrite(56, 4, 32'h2000_0002, 1'b0, sig1);
    bread(56, 4, 2);
    drain();

    // R9 malformed commands
    chk(s_err == 1'b0, "R9 no error yet", 64'(s_err), 64'd0);
    s_rd = 0; s_wr = 1; s_addr = 6'd34; s_be = 4'hF; s_burst = 4'd2; s_wdata = 32'hDEAD_0000;
    hs(acc, stl); idle();
    chk(stl == 0, "R9 no stall on bad", 64'(stl), 64'd0);
    #1 chk(s_err == 1'b1, "R9 error set", 64'(s_err), 64'd1);
    s_rd = 1; s_wr = 0; s_addr = 6'd0; s_be = 4'h7; s_burst = 4'd4;
    hs(acc, stl); idle();
    s_rd = 0; s_wr = 1; s_addr = 6'd8; s_be = 4'hF; s_burst = 4'd0; s_wdata = 32'hBAD0_BAD0;
    hs(acc, stl); idle();
    sread(32); sread(36); sread(8);
    drain();
    chk(s_err == 1'b1, "R9 sticky", 64'(s_err), 64'd1);

    // R10 replay after reset
    do_reset();
    chk(s_err == 1'b0, "R9 cleared by reset", 64'(s_err), 64'd0);
    sread(40);                           // flags cleared: poison (R3)
    drain();
    do_reset();
    bwrite(16, 6, 32'h3000_0003, 1'b1, sig1);
    do_reset();
    bwrite(16, 6, 32'h3000_0003, 1'b1, sig2);
    chk(sig1 == sig2, "R10 stall replay", 64'(sig1), 64'(sig2));
    bread(16, 6, 2);
    drain();

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule